// File: doc/BRIEF.md
# Stacked register frame translator

The translator sits in front of a 128-entry integer register file. The file has a fixed global area and a stacked area above it. Software sizes each procedure's frame at run time. An allocate command sets the frame's local and output counts and the size of a rotating sub-region. A call slides the frame base up past the caller's locals, so the caller's output registers become the first registers of the callee. A return brings back the caller's frame from a small internal stack of saved markers. A rotate event steps the rotating base, which renames the registers inside the rotating sub-region.

Each cycle the block translates three logical register numbers: two read ports and one write port. Translation is combinational from the current frame marker. Marker updates take effect on the cycle after the command's clock edge. A stacked access outside the current frame raises a fault and blocks the write. Register 0 can never be written. The register storage, spilling to memory and the other register files belong to neighbouring blocks.

Top module: `regframe_xlate`

## Requirements
- R1: Logical registers 0..31 map to the same physical index, whatever the marker holds.
- R2: A stacked logical register r (32..127) outside the rotating sub-region maps to base + (r-32). When that sum exceeds 127, 96 is subtracted, so physical indices of stacked registers always stay in 32..127.
- R3: For offsets o = r-32 below the rotating size, the offset used is (o + rrb) mod rotating size. A rotate event raises rrb by one, wrapping to 0 at the rotating size. Rotate has no effect when the rotating size is 0. An accepted allocate clears rrb.
- R4: When a requested stacked access has r-32 at or above the frame size, fault_o goes high in the same cycle. For the write port, wr_en_o stays low.
- R5: A write to logical register 0 keeps wr_en_o low. A read of register 0 yields physical index 0.
- R6: An accepted allocate sets frame size = locals + outputs and local count = locals, sets the rotating size, and leaves the base unchanged. The new marker is visible from the cycle after the command edge.
- R7: An allocate is rejected in three cases: locals + outputs exceeds 96, the rotating size is not a multiple of 8, or the rotating size exceeds the frame size. On a rejection err_o is high for exactly the next cycle and the marker is unchanged.
- R8: A call pushes the marker. It then sets base = base + local count, using the R2 wrap, and frame size = frame size - local count. It clears the local count, the rotating size and rrb.
- R9: A return pops the most recently pushed marker. Nesting of up to DEPTH (default 4) calls is restored in order.
- R10: A call with DEPTH markers already saved, or a return with none saved, sets err_o for the next cycle and leaves the marker unchanged.
- R11: After reset the base is 32, all counts are 0 and err_o is 0, so every requested stacked access faults.
- R12: When several commands arrive in one cycle, only one is applied. The priority order is allocate, call, return, rotate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate command |
| alloc_loc_i | input | 7 | Local count for allocate |
| alloc_out_i | input | 7 | Output count for allocate |
| alloc_rot_i | input | 7 | Rotating size for allocate |
| call_i | input | 1 | Call event |
| ret_i | input | 1 | Return event |
| rotate_i | input | 1 | Rotate event |
| rd0_req_i | input | 1 | Read port 0 active |
| rd0_idx_i | input | 7 | Read port 0 logical register |
| rd1_req_i | input | 1 | Read port 1 active |
| rd1_idx_i | input | 7 | Read port 1 logical register |
| wr_req_i | input | 1 | Write port active |
| wr_idx_i | input | 7 | Write port logical register |
| rd0_phys_o | output | 7 | Read port 0 physical index |
| rd1_phys_o | output | 7 | Read port 1 physical index |
| wr_phys_o | output | 7 | Write port physical index |
| wr_en_o | output | 1 | Write allowed |
| fault_o | output | 1 | Out-of-frame access on an active port |
| err_o | output | 1 | Previous command rejected |

## Verification
A corrupted base, local count or rrb moves every stacked index by the same amount on the next cycle after the command. A translation of register 32, or of a register near the top of the frame, exposes it at once. A wrong frame size shows up as a fault that appears or vanishes at the frame edge. The bench therefore probes indices just inside and just outside the frame after each command. A damaged saved-marker stack stays hidden until the matching return. The bench unwinds nested calls and checks each restored frame.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int NREG  = 128;
  localparam int NGLOB = 32;
  localparam int IW    = $clog2(NREG);
  localparam int NSTK  = NREG - NGLOB;
  localparam int RGRAN = 8;
  localparam int RGB   = $clog2(RGRAN);

  typedef struct packed {
    logic [IW-1:0] base;
    logic [IW-1:0] sof;
    logic [IW-1:0] sol;
    logic [IW-1:0] sor;
    logic [IW-1:0] rrb;
  } marker_t;

  // add inside the stacked region, wrapping past the top back to NGLOB
  function automatic logic [IW-1:0] wrap_add(logic [IW-1:0] a, logic [IW-1:0] b);
    logic [IW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (IW+1)'(NREG)) s = s - (IW+1)'(NSTK);
    return s[IW-1:0];
  endfunction
endpackage

// File: rtl/rf_map.sv
module rf_map
  import regframe_pkg::*;
(
  input  logic [IW-1:0] idx_i,
  input  marker_t       mk_i,
  output logic [IW-1:0] phys_o,
  output logic          oof_o
);
  logic [IW-1:0] ofs, rofs;
  logic [IW:0]   rs;

  always_comb begin
    ofs    = idx_i - IW'(NGLOB);
    rofs   = ofs;
    rs     = '0;
    phys_o = idx_i;
    oof_o  = 1'b0;
    if (idx_i >= IW'(NGLOB)) begin
      oof_o = (ofs >= mk_i.sof);
      if (ofs < mk_i.sor) begin
        rs = {1'b0, ofs} + {1'b0, mk_i.rrb};
        if (rs >= {1'b0, mk_i.sor}) rs = rs - {1'b0, mk_i.sor};
        rofs = rs[IW-1:0];
      end
      phys_o = wrap_add(mk_i.base, rofs);
    end
  end
endmodule

// File: rtl/rf_marker.sv
module rf_marker
  import regframe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [IW-1:0] loc_i,
  input  logic [IW-1:0] out_i,
  input  logic [IW-1:0] rot_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          rotate_i,
  output marker_t       mk_o,
  output logic          err_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  marker_t        mk_q, mk_d;
  marker_t        stk [DEPTH];
  logic [SPW-1:0] sp_q, sp_m1;
  logic [IW:0]    sum;
  logic [IW-1:0]  rrb_inc;
  logic           bad_alloc, push, pop, err_d;

  assign sum       = {1'b0, loc_i} + {1'b0, out_i};
  assign bad_alloc = (sum > (IW+1)'(NSTK)) || (rot_i[RGB-1:0] != '0) || ({1'b0, rot_i} > sum);
  assign sp_m1     = sp_q - 1'b1;
  assign rrb_inc   = mk_q.rrb + 1'b1;

  always_comb begin
    mk_d  = mk_q;
    push  = 1'b0;
    pop   = 1'b0;
    err_d = 1'b0;
    if (alloc_i) begin
      if (bad_alloc) err_d = 1'b1;
      else begin
        mk_d.sof = sum[IW-1:0];
        mk_d.sol = loc_i;
        mk_d.sor = rot_i;
        mk_d.rrb = '0;
      end
    end else if (call_i) begin
      if (sp_q == SPW'(DEPTH)) err_d = 1'b1;
      else begin
        push      = 1'b1;
        mk_d.base = wrap_add(mk_q.base, mk_q.sol);
        mk_d.sof  = mk_q.sof - mk_q.sol;
        mk_d.sol  = '0;
        mk_d.sor  = '0;
        mk_d.rrb  = '0;
      end
    end else if (ret_i) begin
      if (sp_q == '0) err_d = 1'b1;
      else begin
        pop  = 1'b1;
        mk_d = stk[sp_m1[PW-1:0]];
      end
    end else if (rotate_i && mk_q.sor != '0) begin
      mk_d.rrb = (rrb_inc == mk_q.sor) ? '0 : rrb_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mk_q  <= '{base: IW'(NGLOB), default: '0};
      sp_q  <= '0;
      err_o <= 1'b0;
    end else begin
      mk_q  <= mk_d;
      err_o <= err_d;
      if (push)     sp_q <= sp_q + 1'b1;
      else if (pop) sp_q <= sp_m1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) stk[sp_q[PW-1:0]] <= mk_q;
  end

  assign mk_o = mk_q;

  // R6
  sof_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_q.sof <= IW'(NSTK));
  // R3
  rrb_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mk_q.sor == '0) ? (mk_q.rrb == '0) : (mk_q.rrb < mk_q.sor));
  // R7
  alloc_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && bad_alloc) |=> (err_o && $stable(mk_q)));
  // R10
  ret_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && !call_i && ret_i && sp_q == '0) |=> (err_o && $stable(mk_q)));
endmodule

// File: rtl/regframe_xlate.sv
module regframe_xlate
  import regframe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [IW-1:0] alloc_loc_i,
  input  logic [IW-1:0] alloc_out_i,
  input  logic [IW-1:0] alloc_rot_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          rotate_i,
  input  logic          rd0_req_i,
  input  logic [IW-1:0] rd0_idx_i,
  input  logic          rd1_req_i,
  input  logic [IW-1:0] rd1_idx_i,
  input  logic          wr_req_i,
  input  logic [IW-1:0] wr_idx_i,
  output logic [IW-1:0] rd0_phys_o,
  output logic [IW-1:0] rd1_phys_o,
  output logic [IW-1:0] wr_phys_o,
  output logic          wr_en_o,
  output logic          fault_o,
  output logic          err_o
);
  localparam int NP = 3;

  marker_t       mk;
  logic [IW-1:0] idx  [NP];
  logic [IW-1:0] phys [NP];
  logic [NP-1:0] oof, req;

  rf_marker #(.DEPTH(DEPTH)) u_marker (
    .clk_i, .rst_ni, .alloc_i,
    .loc_i(alloc_loc_i), .out_i(alloc_out_i), .rot_i(alloc_rot_i),
    .call_i, .ret_i, .rotate_i, .mk_o(mk), .err_o
  );

  assign idx[0] = rd0_idx_i;
  assign idx[1] = rd1_idx_i;
  assign idx[2] = wr_idx_i;
  assign req    = {wr_req_i, rd1_req_i, rd0_req_i};

  for (genvar g = 0; g < NP; g++) begin : g_port
    rf_map u_map (.idx_i(idx[g]), .mk_i(mk), .phys_o(phys[g]), .oof_o(oof[g]));
  end

  assign rd0_phys_o = phys[0];
  assign rd1_phys_o = phys[1];
  assign wr_phys_o  = phys[2];
  assign fault_o    = |(req & oof);
  assign wr_en_o    = wr_req_i && !oof[2] && (wr_idx_i != '0);

  // R2
  stacked_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_i >= IW'(NGLOB)) |-> (wr_phys_o >= IW'(NGLOB)));
  // R5
  zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_i == '0) |-> !wr_en_o);
  // R4
  fault_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !fault_o || rd0_req_i || rd1_req_i);
endmodule

// File: tb/tb_regframe_xlate.sv
`timescale 1ns/1ps
module tb_regframe_xlate;
  localparam int CLK = 20;

  logic clk = 0, rst_ni = 0;
  logic alloc = 0, call = 0, ret = 0, rot = 0;
  logic [6:0] loc = 0, outc = 0, rsz = 0;
  logic rd0_req = 0, rd1_req = 0, wr_req = 0;
  logic [6:0] rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [6:0] rd0_phys, rd1_phys, wr_phys;
  logic wr_en, fault, err;
  int nchk = 0, nerr = 0;

  always #(CLK/2) clk = ~clk;

  regframe_xlate dut (
    .clk_i(clk), .rst_ni, .alloc_i(alloc), .alloc_loc_i(loc), .alloc_out_i(outc),
    .alloc_rot_i(rsz), .call_i(call), .ret_i(ret), .rotate_i(rot),
    .rd0_req_i(rd0_req), .rd0_idx_i(rd0_idx), .rd1_req_i(rd1_req), .rd1_idx_i(rd1_idx),
    .wr_req_i(wr_req), .wr_idx_i(wr_idx), .rd0_phys_o(rd0_phys), .rd1_phys_o(rd1_phys),
    .wr_phys_o(wr_phys), .wr_en_o(wr_en), .fault_o(fault), .err_o(err)
  );

  // after R6 allocate(16,8,8), base 32, rrb 0: {idx, phys, fault}
  localparam int NV = 7;
  localparam int vt [NV][3] = '{
    '{3, 3, 0}, '{32, 32, 0}, '{39, 39, 0}, '{40, 40, 0},
    '{55, 55, 0}, '{56, 0, 1}, '{127, 0, 1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic xl(input string tag, input int i, input int ph, input int f);
    rd0_idx = 7'(i); rd0_req = 1; #1;
    chk(tag, int'(fault), f);
    if (f == 0) chk(tag, int'(rd0_phys), ph);
  endtask

  task automatic cmd(input bit a, input bit c, input bit r, input bit ro,
                     input int l, input int o, input int s);
    alloc = a; call = c; ret = r; rot = ro;
    loc = 7'(l); outc = 7'(o); rsz = 7'(s);
    @(posedge clk); @(negedge clk);
    alloc = 0; call = 0; ret = 0; rot = 0;
  endtask

  initial begin
    #(CLK * 200000);
    nerr++;
    $display("FAIL watchdog act=1 exp=0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK*3); @(negedge clk); rst_ni = 1;
    // R11 reset state
    chk("R11 err", int'(err), 0);
    xl("R11 stacked faults", 32, 0, 1);
    xl("R1 global", 5, 5, 0);

    // R6 allocate, table walk
    cmd(1, 0, 0, 0, 16, 8, 8);
    chk("R6 err", int'(err), 0);
    for (int k = 0; k < NV; k++) xl("R6 R2 R4 table", vt[k][0], vt[k][1], vt[k][2]);

    // R3 rotation
    repeat (3) cmd(0, 0, 0, 1, 0, 0, 0);
    xl("R3 rot 32", 32, 35, 0);
    xl("R3 rot 37", 37, 32, 0);
    xl("R3 rot 39", 39, 34, 0);
    xl("R3 non-rot 40", 40, 40, 0);
    rd0_req = 0;

    // R5, R4 write port
    wr_req = 1; wr_idx = 0; #1;
    chk("R5 wr r0 en", int'(wr_en), 0);
    chk("R5 r0 phys", int'(wr_phys), 0);
    wr_idx = 56; #1;
    chk("R4 wr oof en", int'(wr_en), 0);
    chk("R4 wr oof fault", int'(fault), 1);
    wr_idx = 45; #1;
    chk("R2 wr en", int'(wr_en), 1);
    chk("R2 wr phys", int'(wr_phys), 45);
    wr_idx = 32; #1;
    chk("R3 wr rot phys", int'(wr_phys), 35);
    wr_req = 0;

    // R8 call
    cmd(0, 1, 0, 0, 0, 0, 0);
    xl("R8 callee r32", 32, 48, 0);
    xl("R8 callee r39", 39, 55, 0);
    xl("R8 callee r40", 40, 0, 1);
    rd0_req = 0;
    rd1_req = 1; rd1_idx = 10; #1;
    chk("R1 rd1 global", int'(rd1_phys), 10);
    rd1_req = 0;

    // R2 wrap with full frame, R6 base kept
    cmd(1, 0, 0, 0, 90, 6, 0);
    xl("R2 wrap 127", 127, 47, 0);
    xl("R2 top 111", 111, 127, 0);
    xl("R2 wrap 112", 112, 32, 0);

    // R7 rejects
    cmd(1, 0, 0, 0, 90, 7, 0);
    chk("R7 too big err", int'(err), 1);
    cmd(1, 0, 0, 0, 16, 8, 12);
    chk("R7 rot gran err", int'(err), 1);
    xl("R7 marker kept", 127, 47, 0);
    cmd(1, 0, 0, 0, 4, 4, 16);
    chk("R7 rot>sof err", int'(err), 1);
    xl("R7 marker kept 2", 127, 47, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 err one cycle", int'(err), 0);

    // R8 nested call, R9 unwind
    cmd(0, 1, 0, 0, 0, 0, 0);
    xl("R8 nested r32", 32, 42, 0);
    xl("R8 nested r37", 37, 47, 0);
    xl("R8 nested r38", 38, 0, 1);
    cmd(0, 0, 1, 0, 0, 0, 0);
    xl("R9 ret1", 127, 47, 0);
    cmd(0, 0, 1, 0, 0, 0, 0);
    xl("R9 ret2 rot kept", 32, 35, 0);
    xl("R9 ret2 size", 56, 0, 1);

    // R10 empty return
    cmd(0, 0, 1, 0, 0, 0, 0);
    chk("R10 ret empty err", int'(err), 1);
    xl("R10 ret empty kept", 32, 35, 0);

    // R10 full stack call
    repeat (4) cmd(0, 1, 0, 0, 0, 0, 0);
    cmd(1, 0, 0, 0, 4, 4, 0);
    cmd(0, 1, 0, 0, 0, 0, 0);
    chk("R10 call full err", int'(err), 1);
    xl("R10 call full kept", 39, 55, 0);

    // R12 alloc beats return
    cmd(1, 0, 1, 0, 8, 8, 0);
    chk("R12 err", int'(err), 0);
    xl("R12 alloc wins", 47, 63, 0);
    rd0_req = 0;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule